// File: doc/BRIEF.md
# Multiphase Regulator Fault Supervisor

This block is the digital fault manager of a multiphase core voltage regulator that shares a package with a companion graphics rail. Once per switching cycle it receives one overcurrent comparator flag per phase. It also receives a digitized output-voltage code, the maximum-voltage setting and the status of the offset pin. From these it produces per-phase high-side blanking, a request to tri-state the PWM outputs, a request to force low-side on, the latched overcurrent (OCP) and overvoltage (OVP) status, and a soft-shutdown request to the companion rail.

Overcurrent is counted separately in each phase. A run of consecutive flagged switching cycles latches OCP, and any clean cycle restarts that phase's count. Overvoltage compares the voltage code against the maximum setting plus a fixed margin. The margin is chosen once, when reset is released, from the offset pin. An excursion must persist across a programmable number of microsecond ticks before OVP latches. Both latches clear only on reset.

Top module: `vr_fault_supervisor`

## Requirements
- R1: In any clock where `oc_flag_i[p]` is high, `hs_block_o[p]` is high in the same clock.
- R2: On the `cyc_tick_i` strobe, a phase's counter advances when its flag is high. OCP latches at the clock edge of the OC_LIMIT-th consecutive flagged strobe of any one phase.
- R3: A strobe that finds a phase's flag low returns that phase's count to zero, so an interrupted run never latches OCP.
- R4: With OCP latched and OVP not latched, `pwm_hiz_o` is high.
- R5: `shutdown_req_o` is high whenever OCP or OVP is latched.
- R6: After the first clock edge following reset release, the output is over threshold when `vout_i > vmax_i + OFS_NORM`. The code is 5 mV per LSB and OFS_NORM defaults to 30 (150 mV). A value equal to the threshold does not trip.
- R7: OVP latches only at the clock edge of the DLY_TICKS-th `us_tick_i` counted while over threshold without a break. A single clean clock restarts the count.
- R8: `ofs_hi_i` is sampled once, at the first clock edge after reset release. If it was high, the margin is OFS_HIGH instead (default 170, 850 mV). Later changes of the pin have no effect.
- R9: With OVP latched, `ls_force_o` is high and every bit of `hs_block_o` is high.
- R10: With both faults latched, `ls_force_o` is high and `pwm_hiz_o` is low.
- R11: Once set, OCP and OVP stay latched until `rst_ni` is asserted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on reset) |
| cyc_tick_i | input | 1 | One-clock strobe per switching cycle |
| oc_flag_i | input | NUM_PHASES | Per-phase overcurrent comparator flags |
| us_tick_i | input | 1 | One-clock strobe per microsecond |
| vout_i | input | VCODE_W | Output voltage code, 5 mV/LSB |
| vmax_i | input | VCODE_W | Maximum operating voltage code, 5 mV/LSB |
| ofs_hi_i | input | 1 | Offset pin above its level threshold |
| hs_block_o | output | NUM_PHASES | Hold high-side gate off, per phase |
| pwm_hiz_o | output | 1 | Tri-state all PWM outputs |
| ls_force_o | output | 1 | Force low-side on, high-side off, all phases |
| ocp_latched_o | output | 1 | Overcurrent fault latched |
| ovp_latched_o | output | 1 | Overvoltage fault latched |
| shutdown_req_o | output | 1 | Soft-shutdown request to companion rail |

## Verification
The bench builds the block with three phases, OC_LIMIT of 4 and DLY_TICKS of 2, keeping the default 9-bit code and margins. A short limit makes it cheap to run an interrupted three-strobe run next to a tripping four-strobe run. A two-tick window lets one excursion catch a single microsecond tick and recover, while a longer one latches. The default margins still put the equal-to-threshold boundary at codes 130 and 270 against a setting of 100.

// File: rtl/vrfs_pkg.sv
`timescale 1ns/1ps
package vrfs_pkg;
  typedef enum logic [1:0] {
    DRV_RUN   = 2'd0,
    DRV_HIZ   = 2'd1,
    DRV_LS_ON = 2'd2
  } drv_mode_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/vrfs_oc_phase.sv
`timescale 1ns/1ps
module vrfs_oc_phase #(
  parameter int unsigned OC_LIMIT = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_tick_i,
  input  logic oc_i,
  output logic trip_o
);
  localparam int unsigned CW = vrfs_pkg::cnt_width(OC_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(OC_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cyc_tick_i) begin
      if (!oc_i)            cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip_o = cyc_tick_i & oc_i & (cnt_q == LAST);

  AST_OC_CLEAN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_tick_i && !oc_i) |=> (cnt_q == '0)); // R3
  AST_OC_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_OC_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/vrfs_ovp_detect.sv
`timescale 1ns/1ps
module vrfs_ovp_detect #(
  parameter int unsigned VCODE_W   = 9,
  parameter int unsigned OFS_NORM  = 30,
  parameter int unsigned OFS_HIGH  = 170,
  parameter int unsigned DLY_TICKS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VCODE_W-1:0] vout_i,
  input  logic [VCODE_W-1:0] vmax_i,
  input  logic               ofs_hi_i,
  input  logic               us_tick_i,
  output logic               trip_o
);
  localparam int unsigned TW = VCODE_W + 2;
  localparam int unsigned DW = vrfs_pkg::cnt_width(DLY_TICKS);
  localparam logic [DW-1:0] LAST = DW'(DLY_TICKS - 1);

  logic          armed_q, ofs_sel_q;
  logic [DW-1:0] dcnt_q;
  logic [TW-1:0] thr, vext;
  logic          over;

  assign thr  = TW'(vmax_i) + (ofs_sel_q ? TW'(OFS_HIGH) : TW'(OFS_NORM));
  assign vext = TW'(vout_i);
  assign over = vext > thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      ofs_sel_q <= 1'b0;
      dcnt_q    <= '0;
    end else begin
      if (!armed_q) begin
        armed_q   <= 1'b1;
        ofs_sel_q <= ofs_hi_i;  // margin picked once at POR release
      end
      if (!armed_q || !over)               dcnt_q <= '0;
      else if (us_tick_i && dcnt_q != LAST) dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign trip_o = armed_q & over & us_tick_i & (dcnt_q == LAST);

  AST_OVP_OFS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(ofs_sel_q)); // R8
  AST_OVP_BREAK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !over) |=> (dcnt_q == '0)); // R7
  AST_OVP_ARM_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q); // R6
endmodule

// File: rtl/vr_fault_supervisor.sv
`timescale 1ns/1ps
module vr_fault_supervisor #(
  parameter int unsigned NUM_PHASES = 4,
  parameter int unsigned OC_LIMIT   = 15,
  parameter int unsigned VCODE_W    = 9,
  parameter int unsigned OFS_NORM   = 30,
  parameter int unsigned OFS_HIGH   = 170,
  parameter int unsigned DLY_TICKS  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cyc_tick_i,
  input  logic [NUM_PHASES-1:0] oc_flag_i,
  input  logic                  us_tick_i,
  input  logic [VCODE_W-1:0]    vout_i,
  input  logic [VCODE_W-1:0]    vmax_i,
  input  logic                  ofs_hi_i,
  output logic [NUM_PHASES-1:0] hs_block_o,
  output logic                  pwm_hiz_o,
  output logic                  ls_force_o,
  output logic                  ocp_latched_o,
  output logic                  ovp_latched_o,
  output logic                  shutdown_req_o
);
  import vrfs_pkg::*;

  logic [NUM_PHASES-1:0] ph_trip;
  logic                  ovp_trip;
  logic                  ocp_q, ovp_q;
  drv_mode_e             mode;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    vrfs_oc_phase #(.OC_LIMIT(OC_LIMIT)) u_oc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cyc_tick_i (cyc_tick_i),
      .oc_i       (oc_flag_i[p]),
      .trip_o     (ph_trip[p])
    );
  end

  vrfs_ovp_detect #(
    .VCODE_W   (VCODE_W),
    .OFS_NORM  (OFS_NORM),
    .OFS_HIGH  (OFS_HIGH),
    .DLY_TICKS (DLY_TICKS)
  ) u_ovp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vout_i    (vout_i),
    .vmax_i    (vmax_i),
    .ofs_hi_i  (ofs_hi_i),
    .us_tick_i (us_tick_i),
    .trip_o    (ovp_trip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocp_q <= 1'b0;
      ovp_q <= 1'b0;
    end else begin
      if (|ph_trip) ocp_q <= 1'b1;
      if (ovp_trip) ovp_q <= 1'b1;
    end
  end

  // OVP low-side clamp outranks OCP tri-state
  always_comb begin
    if (ovp_q)      mode = DRV_LS_ON;
    else if (ocp_q) mode = DRV_HIZ;
    else            mode = DRV_RUN;
  end

  assign hs_block_o     = oc_flag_i | {NUM_PHASES{mode == DRV_LS_ON}};
  assign pwm_hiz_o      = (mode == DRV_HIZ);
  assign ls_force_o     = (mode == DRV_LS_ON);
  assign ocp_latched_o  = ocp_q;
  assign ovp_latched_o  = ovp_q;
  assign shutdown_req_o = ocp_q | ovp_q;

  AST_OCP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_q |=> ocp_q); // R11
  AST_OVP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_q |=> ovp_q); // R11
  AST_DRV_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_hiz_o && ls_force_o)); // R10
  AST_OCP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ocp_q) |-> $past(|ph_trip)); // R2
  AST_SD_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_latched_o || ovp_latched_o) |-> shutdown_req_o); // R5
endmodule

// File: tb/tb_vr_fault_supervisor.sv
`timescale 1ns/1ps
module tb_vr_fault_supervisor;
  localparam int NP = 3;
  localparam int LIM = 4;
  localparam int VW = 9;
  localparam int DLY = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_tick_i = 1'b0, us_tick_i = 1'b0, ofs_hi_i = 1'b0;
  logic [NP-1:0] oc_flag_i = '0;
  logic [VW-1:0] vout_i = '0, vmax_i = '0;
  logic [NP-1:0] hs_block_o;
  logic pwm_hiz_o, ls_force_o, ocp_latched_o, ovp_latched_o, shutdown_req_o;

  vr_fault_supervisor #(.NUM_PHASES(NP), .OC_LIMIT(LIM), .VCODE_W(VW), .DLY_TICKS(DLY)) dut (
    .clk_i, .rst_ni, .cyc_tick_i, .oc_flag_i, .us_tick_i, .vout_i, .vmax_i, .ofs_hi_i,
    .hs_block_o, .pwm_hiz_o, .ls_force_o, .ocp_latched_o, .ovp_latched_o, .shutdown_req_o);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int checks = 0, errors = 0, k = 0;
  bit done = 0;
  // stimulus requests
  bit rst_req = 0, ofs_req = 0, cyc_en = 1;
  int oc_req = 0, vout_req = 0, vmax_req = 100;
  // reference model
  int  m_cnt[NP];
  bit  m_ocp, m_ovp, m_armed, m_ofs;
  int  m_dcnt;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (m_cnt[i]) m_cnt[i] = 0;
    m_ocp = 0; m_ovp = 0; m_armed = 0; m_ofs = 0; m_dcnt = 0;
  endtask

  task automatic step(int n);
    for (int c = 0; c < n; c++) begin
      int hs_exp, thr;
      bit over;
      @(negedge clk_i);
      hs_exp = int'(oc_flag_i) | (m_ovp ? ((1 << NP) - 1) : 0);
      chk(m_ovp ? "R9" : "R1", "hs_block", int'(hs_block_o), hs_exp);
      chk(m_ovp ? "R10" : "R4", "pwm_hiz", int'(pwm_hiz_o), int'(m_ocp && !m_ovp));
      chk("R9", "ls_force", int'(ls_force_o), int'(m_ovp));
      chk("R2", "ocp_latched", int'(ocp_latched_o), int'(m_ocp));
      chk("R6", "ovp_latched", int'(ovp_latched_o), int'(m_ovp));
      chk("R5", "shutdown", int'(shutdown_req_o), int'(m_ocp || m_ovp));
      // drive next inputs
      k++;
      rst_ni     = rst_req;
      cyc_tick_i = cyc_en && (k % 2 == 0);
      us_tick_i  = (k % 5 == 0);
      oc_flag_i  = NP'(oc_req);
      vout_i     = VW'(vout_req);
      vmax_i     = VW'(vmax_req);
      ofs_hi_i   = ofs_req;
      // model the coming edge
      if (!rst_req) model_reset();
      else begin
        if (cyc_tick_i)
          for (int p = 0; p < NP; p++) begin
            if (!oc_flag_i[p]) m_cnt[p] = 0;
            else if (m_cnt[p] == LIM - 1) m_ocp = 1;
            else m_cnt[p]++;
          end
        if (!m_armed) begin
          m_armed = 1; m_ofs = ofs_hi_i; m_dcnt = 0;
        end else begin
          thr  = vmax_req + (m_ofs ? 170 : 30);
          over = vout_req > thr;
          if (!over) m_dcnt = 0;
          else if (us_tick_i) begin
            if (m_dcnt == DLY - 1) m_ovp = 1;
            else m_dcnt++;
          end
        end
      end
    end
  endtask

  task automatic do_reset(bit ofs);
    rst_req = 0; ofs_req = ofs; oc_req = 0;
    step(3);
    rst_req = 1;
    step(3);
    chk("R11", "ocp cleared by reset", int'(ocp_latched_o), 0);
    chk("R11", "ovp cleared by reset", int'(ovp_latched_o), 0);
  endtask

  initial begin
    model_reset();
    vout_req = 0;
    do_reset(0);
    step(4);
    // R3: two interrupted runs of three strobes each
    oc_req = 3'b001; step(6);
    oc_req = 3'b000; step(2);
    oc_req = 3'b001; step(6);
    oc_req = 3'b000; step(2);
    chk("R3", "no OCP after interrupted runs", int'(ocp_latched_o), 0);
    // R2/R4: four consecutive strobes on phase 1
    oc_req = 3'b010; step(10);
    chk("R4", "hiz after OCP", int'(pwm_hiz_o), 1);
    oc_req = 3'b000; step(6);
    chk("R11", "OCP holds after flags clear", int'(ocp_latched_o), 1);

    // OVP, normal margin: threshold 130
    do_reset(0);
    vout_req = 130; step(20);
    chk("R6", "no trip at threshold", int'(ovp_latched_o), 0);
    vout_req = 131; step(3);
    vout_req = 130; step(4);
    chk("R7", "short excursion ignored", int'(ovp_latched_o), 0);
    vout_req = 131; step(15);
    chk("R7", "sustained excursion trips", int'(ovp_latched_o), 1);
    chk("R9", "ls forced", int'(ls_force_o), 1);
    oc_req = 3'b111; step(12);
    chk("R10", "OVP outranks hiz", int'(pwm_hiz_o), 0);
    oc_req = 0; vout_req = 0; step(4);
    chk("R11", "OVP holds after voltage drops", int'(ovp_latched_o), 1);

    // OVP, high margin: threshold 270, pin drops after capture
    do_reset(1);
    ofs_req = 0;
    vout_req = 200; step(20);
    chk("R8", "no trip below raised threshold", int'(ovp_latched_o), 0);
    vout_req = 270; step(15);
    chk("R8", "no trip at raised threshold", int'(ovp_latched_o), 0);
    vout_req = 271; step(15);
    chk("R8", "trip above raised threshold", int'(ovp_latched_o), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule